// File: doc/BRIEF.md
# Interrupt Status Enable Router

This block gathers up to 32 interrupt causes into one status word, filters them through two separate enable words, and steers each surviving cause onto one of four interrupt wires. Causes 1 to 7 are level requests: their status bits copy the request line (gated by the latch enable) one cycle later, and software cannot clear them. All other implemented causes are one-cycle event pulses. Each pulse is held in status until software writes a one to that bit of the clear word, or until its latch enable is removed.

A cause drives a wire when three things are true: its status bit is set, its output-enable bit is set, and its 2-bit wire field selects that wire. The wire fields sit in two map words, with causes 0 to 15 in the first and causes 16 to 31 in the second. For each wire the block also gives the index of the highest-numbered cause currently driving it. A handler can use that index to serve causes from the top down without scanning the status word.

Registers are reached through a flat word-indexed write port with a combinational read port.

Top module: `irq_steer`

## Requirements
- R1: After reset every register reads zero, all wires are low and every top-index field is zero.
- R2: An event cause (implemented bits 8 to 25) with its latch-enable bit set is captured in status at the clock edge where its input is high. It stays set after the input drops.
- R3: An event pulse on a cause whose latch-enable bit is zero leaves the status bit zero.
- R4: Writing the clear word (index 3) clears exactly the event status bits written as one. Other bits are not affected.
- R5: Status bits 1 to 7 equal the request input ANDed with the latch enable, one clock after the input is sampled. A clear write has no effect on them.
- R6: A write that removes a latch-enable bit also clears that status bit at the same clock edge.
- R7: When an event pulse and a clear of the same bit occur in the same cycle, the status bit ends up set.
- R8: The output enable (index 1) gates only the wires. A wire is high exactly when some cause with status and output enable both set is mapped to it. Status is not affected by the output enable.
- R9: Cause i (i < 16) selects its wire with map word 0 bits [2i+1:2i]. Cause i (i ≥ 16) uses map word 1 bits [2(i-16)+1:2(i-16)]. The field value is the wire number.
- R10: Each wire's top-index field (5 bits, wire w at irq_top[5w+4:5w]) holds the highest cause number driving that wire, or 0 when the wire is low.
- R11: Status bits 0, 14, 15 and 26 to 31 are never set.
- R12: Register indices are: 0 latch enable, 1 output enable, 2 status (read-only; writes ignored), 3 clear (reads zero), 4 map word 0, 5 map word 1. The enable and map words read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Cause inputs: levels on bits 1-7, pulses elsewhere |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_wire | output | 4 | Interrupt wires |
| irq_top | output | 20 | Per-wire highest driving cause index, 5 bits per wire |

## Verification
The bench aims at the collision of an event pulse and a clear of the same bit. A design that lets the clear win would lose that interrupt. It also issues a clear write aimed at level bits while their request is still high: a design that clears them would drop a request that is still pending. It removes a latch enable while its bit is set, which catches a status bit left stranded with no way to clear it. It raises output enables both before and after causes latch, and rewrites the mapping. This exposes a wire gated by the wrong enable, a map field read from the wrong position, or a top index that reports the lowest cause rather than the highest.

// File: rtl/irq_steer_pkg.sv
// Shared constants for the interrupt router.
// Assumes a 32-bit register word and a cause count equal to it.
package irq_steer_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_LATCH_EN = 3'd0,
        RA_OUT_EN   = 3'd1,
        RA_STATUS   = 3'd2,
        RA_CLEAR    = 3'd3,
        RA_MAP0     = 3'd4,
        RA_MAP1     = 3'd5
    } reg_addr_e;

    // Causes that exist; all others stay zero in status.
    localparam logic [DATA_W-1:0] IMPL_MASK  = 32'h03FF_3FFE;
    // Causes that follow a level request and cannot be cleared.
    localparam logic [DATA_W-1:0] LEVEL_MASK = 32'h0000_00FE;
endpackage

// File: rtl/irq_regfile.sv
// Register storage: the two enable words and the wire-map words.
// It also produces the clear strobe and the read mux.
// Assumes single-cycle writes and a combinational read.
module irq_regfile
    import irq_steer_pkg::*;
#(
    parameter int unsigned NWIRE  = 4,
    localparam int unsigned WSEL_W = $clog2(NWIRE),
    localparam int unsigned NMAP   = WSEL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W-1:0]        status,
    output logic [DATA_W-1:0]        en_q,
    output logic [DATA_W-1:0]        en_nx,
    output logic [DATA_W-1:0]        oen_q,
    output logic [DATA_W-1:0]        clr,
    output logic [NMAP*DATA_W-1:0]   map_flat,
    output logic [DATA_W-1:0]        rdata
);
    logic [NMAP-1:0][DATA_W-1:0] map_q;

    // Next latch-enable value, seen by the status bank in the same cycle.
    always_comb en_nx = (we && addr == RA_LATCH_EN) ? wdata : en_q;

    // Clear strobe: active only during a write to the clear index.
    always_comb clr = (we && addr == RA_CLEAR) ? wdata : '0;

    // Enable word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            oen_q <= '0;
        end else begin
            en_q <= en_nx;
            if (we && addr == RA_OUT_EN) oen_q <= wdata;
        end
    end

    // One storage word per map register.
    for (genvar k = 0; k < NMAP; k++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[k] <= '0;
            else if (we && addr == ADDR_W'(int'(RA_MAP0) + k))
                map_q[k] <= wdata;
        end
    end

    assign map_flat = map_q;

    // Read mux; the clear index and unused indices read zero.
    always_comb begin
        rdata = '0;
        case (addr)
            RA_LATCH_EN: rdata = en_q;
            RA_OUT_EN:   rdata = oen_q;
            RA_STATUS:   rdata = status;
            default: begin
                for (int k = 0; k < NMAP; k++)
                    if (addr == ADDR_W'(int'(RA_MAP0) + k)) rdata = map_q[k];
            end
        endcase
    end
endmodule

// File: rtl/irq_status.sv
// Status bank: level causes track their request, event causes latch.
// A clear write releases only event bits. An arriving event beats a clear.
// Assumes en_nx already holds any latch-enable write made this cycle.
module irq_status
    import irq_steer_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMPL  = IMPL_MASK,
    parameter logic [DATA_W-1:0] LEVEL = LEVEL_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] en_nx,
    input  logic [DATA_W-1:0] clr,
    output logic [DATA_W-1:0] st_q
);
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] st_nx;

    // Held event bits that survive this cycle's clear.
    always_comb keep = st_q & ~clr & ~LEVEL;

    // Next status: the enable gates both the capture and the holding.
    always_comb st_nx = IMPL & en_nx & ((src & LEVEL) | ((src & ~LEVEL) | keep));

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_nx;
    end
endmodule

// File: rtl/irq_route.sv
// Wire router: for every wire, ORs the pending causes mapped to it and
// picks the highest one. Purely combinational.
// Assumes pending is already status AND output enable.
module irq_route #(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned NWIRE  = 4,
    localparam int unsigned WSEL_W = $clog2(NWIRE),
    localparam int unsigned IDX_W  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]        pending,
    input  logic [NSRC*WSEL_W-1:0] map_flat,
    output logic [NWIRE-1:0]       wire_act,
    output logic [NWIRE*IDX_W-1:0] top_idx
);
    for (genvar w = 0; w < NWIRE; w++) begin : g_wire
        logic [NSRC-1:0]  hit;
        logic [IDX_W-1:0] idx;

        // Causes that are pending and select this wire.
        always_comb begin
            for (int i = 0; i < NSRC; i++)
                hit[i] = pending[i] && (map_flat[i*WSEL_W +: WSEL_W] == WSEL_W'(w));
        end

        // Highest hit wins, because the later loop pass overrides.
        always_comb begin
            idx = '0;
            for (int i = 0; i < NSRC; i++)
                if (hit[i]) idx = IDX_W'(i);
        end

        assign wire_act[w]                = |hit;
        assign top_idx[w*IDX_W +: IDX_W]  = idx;
    end
endmodule

// File: rtl/irq_steer.sv
// Top of the interrupt router. It joins the register file, the status bank
// and the wire router. Assumes a single clock and synchronous reset.
module irq_steer
    import irq_steer_pkg::*;
#(
    parameter int unsigned NWIRE  = 4,
    localparam int unsigned WSEL_W = $clog2(NWIRE),
    localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        src_in,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic [NWIRE-1:0]         irq_wire,
    output logic [NWIRE*IDX_W-1:0]   irq_top
);
    logic [DATA_W-1:0]        en_q;
    logic [DATA_W-1:0]        en_nx;
    logic [DATA_W-1:0]        oen_q;
    logic [DATA_W-1:0]        clr;
    logic [DATA_W-1:0]        st_q;
    logic [DATA_W-1:0]        pending;
    logic [DATA_W*WSEL_W-1:0] map_flat;

    irq_regfile #(.NWIRE(NWIRE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .status   (st_q),
        .en_q     (en_q),
        .en_nx    (en_nx),
        .oen_q    (oen_q),
        .clr      (clr),
        .map_flat (map_flat),
        .rdata    (reg_rdata)
    );

    irq_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_in),
        .en_nx (en_nx),
        .clr   (clr),
        .st_q  (st_q)
    );

    // Causes allowed onto a wire.
    assign pending = st_q & oen_q;

    irq_route #(.NSRC(DATA_W), .NWIRE(NWIRE)) u_route (
        .pending  (pending),
        .map_flat (map_flat),
        .wire_act (irq_wire),
        .top_idx  (irq_top)
    );
endmodule

// File: rtl/irq_steer_chk.sv
// Checker for irq_steer, attached with bind. It observes the ports plus the
// internal enable and status words.
module irq_steer_chk
    import irq_steer_pkg::*;
#(
    parameter int unsigned NWIRE = 4,
    localparam int unsigned IDX_W = $clog2(DATA_W)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [DATA_W-1:0]      src_in,
    input logic [DATA_W-1:0]      en_q,
    input logic [DATA_W-1:0]      oen_q,
    input logic [DATA_W-1:0]      st_q,
    input logic [NWIRE-1:0]       irq_wire,
    input logic [NWIRE*IDX_W-1:0] irq_top
);
    localparam logic [DATA_W-1:0] EVT = IMPL_MASK & ~LEVEL_MASK;
    logic past_ok;

    // Marks cycles whose previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r11_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q & ~IMPL_MASK) == '0);

    a_r6_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q & ~en_q) == '0);

    a_r5_level_track: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((st_q & LEVEL_MASK) == ($past(src_in) & en_q & LEVEL_MASK)));

    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((($past(src_in) & EVT & en_q) & ~st_q) == '0));

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((st_q & EVT & ~$past(st_q) & ~$past(src_in)) == '0));

    a_r8_idle_wires: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & oen_q) == '0) |-> (irq_wire == '0));

    for (genvar w = 0; w < NWIRE; w++) begin : g_wchk
        a_r10_top_pending: assert property (@(posedge clk) disable iff (!rst_n)
            irq_wire[w] |-> (st_q[irq_top[w*IDX_W +: IDX_W]] && oen_q[irq_top[w*IDX_W +: IDX_W]]));
        a_r10_top_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_wire[w] |-> (irq_top[w*IDX_W +: IDX_W] == '0));
    end
endmodule

bind irq_steer irq_steer_chk #(.NWIRE(NWIRE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (src_in),
    .en_q     (en_q),
    .oen_q    (oen_q),
    .st_q     (st_q),
    .irq_wire (irq_wire),
    .irq_top  (irq_top)
);

// File: tb/sim_irq_steer.sv
module sim_irq_steer;
    import irq_steer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_wire;
    logic [19:0] irq_top;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_steer u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_wire(irq_wire), .irq_top(irq_top)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] clr;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Latch enable all ones; each row is one pulse cycle, then status is read.
    localparam vec_t TBL [9] = '{
        '{32'h0000_0100, 32'h0,         32'h0000_0100, 4'd2},  // R2 event 8
        '{32'h0001_0000, 32'h0,         32'h0001_0100, 4'd2},  // R2 event 16 joins
        '{32'h0,         32'h0000_0100, 32'h0001_0000, 4'd4},  // R4 clear only 8
        '{32'h0000_0006, 32'h0,         32'h0001_0006, 4'd5},  // R5 levels 1,2
        '{32'h0000_0006, 32'h0000_0006, 32'h0001_0006, 4'd5},  // R5 clear ignored
        '{32'h0,         32'h0,         32'h0001_0000, 4'd5},  // R5 levels drop
        '{32'h0200_0000, 32'h0200_0000, 32'h0201_0000, 4'd7},  // R7 event beats clear
        '{32'hFC00_C001, 32'h0,         32'h0201_0000, 4'd11}, // R11 unimplemented
        '{32'h0,         32'hFFFF_FFFF, 32'h0,         4'd4}   // R4 clear all
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] s, input logic [31:0] c);
        @(negedge clk);
        src_in = s; reg_we = (c != 0); reg_addr = RA_CLEAR; reg_wdata = c;
        @(negedge clk);
        src_in = '0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] top(input int w);
        return 32'(irq_top[w*5 +: 5]);
    endfunction

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reg", d, 32'h0);
        end
        chk("R1 wires", 32'(irq_wire), 32'h0);
        chk("R1 top", 32'(irq_top), 32'h0);

        wr(RA_LATCH_EN, 32'hFFFF_FFFF);
        for (int i = 0; i < 9; i++) begin
            pulse(TBL[i].src, TBL[i].clr);
            rd(RA_STATUS, d);
            chk($sformatf("R%0d vec%0d", TBL[i].req, i), d, TBL[i].exp);
        end

        // R3 disabled cause ignored
        wr(RA_LATCH_EN, 32'hFFFF_FDFF);
        rd(RA_LATCH_EN, d);
        chk("R12 enable readback", d, 32'hFFFF_FDFF);
        pulse(32'h0000_0200, 32'h0);
        rd(RA_STATUS, d);
        chk("R3 no latch", d, 32'h0);

        // R6 removing enable clears status
        wr(RA_LATCH_EN, 32'hFFFF_FFFF);
        pulse(32'h0000_1000, 32'h0);
        rd(RA_STATUS, d);
        chk("R2 latch 12", d, 32'h0000_1000);
        wr(RA_LATCH_EN, 32'hFFFF_EFFF);
        rd(RA_STATUS, d);
        chk("R6 enable drop", d, 32'h0);
        wr(RA_LATCH_EN, 32'hFFFF_FFFF);

        // R12 status write ignored, clear reads zero
        pulse(32'h0000_2000, 32'h0);
        wr(RA_STATUS, 32'h0);
        rd(RA_STATUS, d);
        chk("R12 status read-only", d, 32'h0000_2000);
        rd(RA_CLEAR, d);
        chk("R12 clear reads zero", d, 32'h0);
        pulse(32'h0, 32'h0000_2000);

        // R9 routing: 8->w1, 16->w2, 20->w2, 24->w3
        wr(RA_MAP0, 32'h0001_0000);
        wr(RA_MAP1, 32'h0003_0202);
        rd(RA_MAP1, d);
        chk("R12 map readback", d, 32'h0003_0202);
        pulse(32'h0111_0100, 32'h0);
        rd(RA_STATUS, d);
        chk("R8 status without output enable", d, 32'h0111_0100);
        chk("R8 wires gated", 32'(irq_wire), 32'h0);
        chk("R10 top idle", 32'(irq_top), 32'h0);
        wr(RA_OUT_EN, 32'hFFFF_FFFF);
        chk("R9 wires", 32'(irq_wire), 32'hE);
        chk("R10 top w0", top(0), 32'd0);
        chk("R10 top w1", top(1), 32'd8);
        chk("R10 top w2", top(2), 32'd20);
        chk("R10 top w3", top(3), 32'd24);
        pulse(32'h0, 32'h0010_0000);
        chk("R10 top w2 after clear", top(2), 32'd16);
        wr(RA_OUT_EN, 32'hFEFF_FFFF);
        chk("R8 wire3 masked", 32'(irq_wire), 32'h6);
        rd(RA_STATUS, d);
        chk("R8 status kept", d, 32'h0101_0100);

        // R5 level 7 on wire 0, visible the cycle after its sample
        pulse(32'h0000_0080, 32'h0);
        chk("R5 level wire0", 32'(irq_wire[0]), 32'h1);
        chk("R10 top w0 level", top(0), 32'd7);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule